// File: doc/BRIEF.md
# Adaptive Row-Buffer Page Policy Controller

This block sits between a memory request stream and the DRAM command issue logic. For every request it looks up the row that is currently latched in the target bank's sense amplifiers. It sorts the request into one of three cases: the wanted row is already open (row hit), the bank has no open row (idle bank), or a different row is open (bank conflict). From that case it emits the command sequence the access needs and the access latency in clock cycles.

Each bank chooses independently, at run time, whether to keep its row open after an access or to close it with an auto-precharge column command. The choice follows a locality statistic. Every bank counts how many of its last 16 accesses went to the same row as the access before them. At the end of each window it compares that count with a programmable threshold. Because the count uses the previous row address and not the open state, a bank that has switched to closed-page behaviour can still detect returning locality and switch back. A caller-supplied hint forces auto-precharge when the next access to the bank is already known to need a different row. A per-bank idle timer closes an open row that has not been touched for longer than a programmable number of cycles.

Top module: `apc_page_ctrl`

## Requirements
- R1: One cycle after an accepted request, `rsp_class` reports 0 when the bank holds the requested row open, 1 when the bank has no open row, and 2 when the bank holds a different row open.
- R2: Command flags per class: class 0 gives a column command only; class 1 gives activate plus column; class 2 gives precharge, activate and column. `rsp_col` is 1 and `rsp_bank`/`rsp_write` echo the request.
- R3: `rsp_latency` is T_CAS for class 0, T_RCD+T_CAS for class 1, and T_RP+T_RCD+T_CAS for class 2. The defaults are 3, 7 and 11.
- R4: The column command carries auto-precharge (`rsp_auto_pre`=1) when the bank is in closed-page mode or `req_next_new_row` is 1. Such a bank then holds no open row. Otherwise the requested row stays open.
- R5: Each bank counts accesses in windows of 16. Within a window it counts those whose row equals the row of that bank's previous access. At the 16th access the bank enters closed-page mode (`bank_closed_mode` bit = 1) if the count is below `cfg_hit_thresh`, and open-page mode otherwise. The mode changes at no other time, and banks are independent.
- R6: A bank's idle timer counts cycles since its last access while a row is open, saturating at all ones. In a cycle with no request, the lowest-numbered bank whose timer is at least `cfg_idle_limit` is closed. This is reported one cycle later on `idle_pre_valid`/`idle_pre_bank`. Idle closing never happens in a cycle that carries a request.
- R7: An access that leaves the row open clears that bank's idle timer to 0.
- R8: After reset every bank holds no open row and is in open-page mode, and `rsp_valid` and `idle_pre_valid` are 0.
- R9: `rsp_valid` is 1 exactly in the cycle after a cycle with `req_valid` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_bank | input | BANK_W | Target bank |
| req_row | input | ROW_W | Target row |
| req_write | input | 1 | 1 for write, 0 for read |
| req_next_new_row | input | 1 | Next access to this bank needs another row |
| cfg_hit_thresh | input | HIT_W | Locality count below which a bank goes closed-page |
| cfg_idle_limit | input | TIMER_W | Idle cycles before an open row is closed |
| rsp_valid | output | 1 | Command sequence valid |
| rsp_bank | output | BANK_W | Bank of the sequence |
| rsp_write | output | 1 | Column command is a write |
| rsp_pre | output | 1 | Sequence starts with precharge |
| rsp_act | output | 1 | Sequence contains activate |
| rsp_col | output | 1 | Sequence contains a column command |
| rsp_auto_pre | output | 1 | Column command closes the row |
| rsp_class | output | 2 | 0 hit, 1 idle bank, 2 conflict |
| rsp_latency | output | LAT_W | Access latency in cycles |
| idle_pre_valid | output | 1 | Idle-timeout precharge issued |
| idle_pre_bank | output | BANK_W | Bank of the idle precharge |
| bank_closed_mode | output | NUM_BANKS | Per-bank closed-page mode flag |

## Verification
Every response and idle precharge is registered once, so it appears in the cycle after the request or quiet cycle that caused it. The bench drives inputs on the falling edge and checks at the next falling edge, after exactly one rising edge. Mode flags change on the same edge as the 16th access of a window, so they are compared at that same falling edge. A cycle-level bench model tracks open rows, timers and window counts, and each check is sampled in the cycle the model predicts.

// File: rtl/apc_pkg.sv
package apc_pkg;
    typedef enum logic [1:0] {
        CLS_HIT      = 2'd0,
        CLS_IDLE     = 2'd1,
        CLS_CONFLICT = 2'd2
    } apc_class_e;
endpackage

// File: rtl/apc_bank.sv
module apc_bank #(
    parameter int ROW_W   = 12,
    parameter int WIN_LEN = 16,
    parameter int TIMER_W = 8,
    localparam int WIN_W  = $clog2(WIN_LEN),
    localparam int HIT_W  = $clog2(WIN_LEN + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               acc_i,
    input  logic [ROW_W-1:0]   acc_row_i,
    input  logic               acc_close_i,
    input  logic               idle_close_i,
    input  logic [HIT_W-1:0]   cfg_thresh_i,
    input  logic [TIMER_W-1:0] cfg_limit_i,
    output logic               open_o,
    output logic [ROW_W-1:0]   row_o,
    output logic               closed_mode_o,
    output logic               expired_o
);
    localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WIN_LEN - 1);

    typedef struct packed {
        logic               open;
        logic [ROW_W-1:0]   row;
        logic [TIMER_W-1:0] timer;
        logic               last_valid;
        logic [ROW_W-1:0]   last_row;
        logic [WIN_W-1:0]   win;
        logic [HIT_W-1:0]   hits;
        logic               closed_mode;
    } bank_st_t;

    bank_st_t st_d, st_q;
    logic     would_hit;
    logic [HIT_W-1:0] hits_now;

    always_comb begin
        st_d      = st_q;
        would_hit = st_q.last_valid && (st_q.last_row == acc_row_i);
        hits_now  = st_q.hits + HIT_W'(would_hit);
        if (acc_i) begin
            st_d.last_valid = 1'b1;
            st_d.last_row   = acc_row_i;
            st_d.open       = !acc_close_i;
            st_d.row        = acc_row_i;
            st_d.timer      = '0;
            if (st_q.win == WIN_LAST) begin
                st_d.closed_mode = (hits_now < cfg_thresh_i);
                st_d.win         = '0;
                st_d.hits        = '0;
            end else begin
                st_d.win  = st_q.win + 1'b1;
                st_d.hits = hits_now;
            end
        end else if (idle_close_i) begin
            st_d.open  = 1'b0;
            st_d.timer = '0;
        end else if (st_q.open && (st_q.timer != '1)) begin
            st_d.timer = st_q.timer + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign open_o        = st_q.open;
    assign row_o         = st_q.row;
    assign closed_mode_o = st_q.closed_mode;
    assign expired_o     = st_q.open && (st_q.timer >= cfg_limit_i);

    AST_CLOSE_AFTER_AUTOPRE: assert property (@(posedge clk) disable iff (!rst_n)
        acc_i && acc_close_i |=> !open_o); // R4
    AST_TIMER_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        acc_i && !acc_close_i |=> open_o && (st_q.timer == '0)); // R7
    AST_MODE_ONLY_AT_WINDOW_END: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_i && (st_q.win == WIN_LAST)) |=> $stable(closed_mode_o)); // R5
endmodule

// File: rtl/apc_idle_arb.sv
module apc_idle_arb #(
    parameter int NUM_BANKS = 4,
    localparam int BANK_W   = $clog2(NUM_BANKS)
) (
    input  logic [NUM_BANKS-1:0] req_i,
    output logic [NUM_BANKS-1:0] grant_o,
    output logic [BANK_W-1:0]    idx_o,
    output logic                 any_o
);
    always_comb begin
        grant_o = '0;
        idx_o   = '0;
        any_o   = 1'b0;
        for (int i = 0; i < NUM_BANKS; i++) begin
            if (req_i[i] && !any_o) begin
                grant_o[i] = 1'b1;
                idx_o      = BANK_W'(i);
                any_o      = 1'b1;
            end
        end
    end
endmodule

// File: rtl/apc_cmd_gen.sv
module apc_cmd_gen #(
    parameter int LAT_W = 6,
    parameter int T_RP  = 4,
    parameter int T_RCD = 4,
    parameter int T_CAS = 3
) (
    input  apc_pkg::apc_class_e cls_i,
    output logic                pre_o,
    output logic                act_o,
    output logic [LAT_W-1:0]    lat_o
);
    import apc_pkg::*;
    localparam logic [LAT_W-1:0] LAT_HIT  = LAT_W'(T_CAS);
    localparam logic [LAT_W-1:0] LAT_IDLE = LAT_W'(T_RCD + T_CAS);
    localparam logic [LAT_W-1:0] LAT_CONF = LAT_W'(T_RP + T_RCD + T_CAS);

    always_comb begin
        unique case (cls_i)
            CLS_HIT:      begin pre_o = 1'b0; act_o = 1'b0; lat_o = LAT_HIT;  end
            CLS_IDLE:     begin pre_o = 1'b0; act_o = 1'b1; lat_o = LAT_IDLE; end
            default:      begin pre_o = 1'b1; act_o = 1'b1; lat_o = LAT_CONF; end
        endcase
    end
endmodule

// File: rtl/apc_page_ctrl.sv
module apc_page_ctrl #(
    parameter int NUM_BANKS = 4,
    parameter int ROW_W     = 12,
    parameter int WIN_LEN   = 16,
    parameter int TIMER_W   = 8,
    parameter int LAT_W     = 6,
    parameter int T_RP      = 4,
    parameter int T_RCD     = 4,
    parameter int T_CAS     = 3,
    localparam int BANK_W   = $clog2(NUM_BANKS),
    localparam int HIT_W    = $clog2(WIN_LEN + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [BANK_W-1:0]    req_bank,
    input  logic [ROW_W-1:0]     req_row,
    input  logic                 req_write,
    input  logic                 req_next_new_row,
    input  logic [HIT_W-1:0]     cfg_hit_thresh,
    input  logic [TIMER_W-1:0]   cfg_idle_limit,
    output logic                 rsp_valid,
    output logic [BANK_W-1:0]    rsp_bank,
    output logic                 rsp_write,
    output logic                 rsp_pre,
    output logic                 rsp_act,
    output logic                 rsp_col,
    output logic                 rsp_auto_pre,
    output logic [1:0]           rsp_class,
    output logic [LAT_W-1:0]     rsp_latency,
    output logic                 idle_pre_valid,
    output logic [BANK_W-1:0]    idle_pre_bank,
    output logic [NUM_BANKS-1:0] bank_closed_mode
);
    import apc_pkg::*;

    typedef struct packed {
        logic              valid;
        logic [BANK_W-1:0] bank;
        logic              write;
        logic              pre;
        logic              act;
        logic              auto_pre;
        apc_class_e        cls;
        logic [LAT_W-1:0]  lat;
        logic              idle_valid;
        logic [BANK_W-1:0] idle_bank;
    } out_t;

    out_t out_d, out_q;

    logic [NUM_BANKS-1:0] bank_open, bank_exp, acc_vec, idle_grant, idle_req;
    logic [ROW_W-1:0]     bank_row [NUM_BANKS];
    logic [BANK_W-1:0]    idle_idx;
    logic                 idle_any;
    logic                 acc_close;
    apc_class_e           cls;
    logic                 cmd_pre, cmd_act;
    logic [LAT_W-1:0]     cmd_lat;

    // request classification against the addressed bank
    always_comb begin
        if (!bank_open[req_bank])                 cls = CLS_IDLE;
        else if (bank_row[req_bank] == req_row)   cls = CLS_HIT;
        else                                      cls = CLS_CONFLICT;
        acc_close = bank_closed_mode[req_bank] | req_next_new_row;
        acc_vec   = req_valid ? ({{(NUM_BANKS-1){1'b0}}, 1'b1} << req_bank) : '0;
        idle_req  = req_valid ? '0 : bank_exp;
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        apc_bank #(
            .ROW_W  (ROW_W),
            .WIN_LEN(WIN_LEN),
            .TIMER_W(TIMER_W)
        ) u_bank (
            .clk          (clk),
            .rst_n        (rst_n),
            .acc_i        (acc_vec[b]),
            .acc_row_i    (req_row),
            .acc_close_i  (acc_close),
            .idle_close_i (idle_grant[b]),
            .cfg_thresh_i (cfg_hit_thresh),
            .cfg_limit_i  (cfg_idle_limit),
            .open_o       (bank_open[b]),
            .row_o        (bank_row[b]),
            .closed_mode_o(bank_closed_mode[b]),
            .expired_o    (bank_exp[b])
        );
    end

    apc_idle_arb #(.NUM_BANKS(NUM_BANKS)) u_idle_arb (
        .req_i  (idle_req),
        .grant_o(idle_grant),
        .idx_o  (idle_idx),
        .any_o  (idle_any)
    );

    apc_cmd_gen #(
        .LAT_W(LAT_W), .T_RP(T_RP), .T_RCD(T_RCD), .T_CAS(T_CAS)
    ) u_cmd_gen (
        .cls_i(cls),
        .pre_o(cmd_pre),
        .act_o(cmd_act),
        .lat_o(cmd_lat)
    );

    always_comb begin
        out_d            = out_q;
        out_d.valid      = req_valid;
        out_d.idle_valid = idle_any;
        out_d.idle_bank  = idle_idx;
        if (req_valid) begin
            out_d.bank     = req_bank;
            out_d.write    = req_write;
            out_d.pre      = cmd_pre;
            out_d.act      = cmd_act;
            out_d.auto_pre = acc_close;
            out_d.cls      = cls;
            out_d.lat      = cmd_lat;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign rsp_valid      = out_q.valid;
    assign rsp_bank       = out_q.bank;
    assign rsp_write      = out_q.write;
    assign rsp_pre        = out_q.pre;
    assign rsp_act        = out_q.act;
    assign rsp_col        = out_q.valid;
    assign rsp_auto_pre   = out_q.auto_pre;
    assign rsp_class      = out_q.cls;
    assign rsp_latency    = out_q.lat;
    assign idle_pre_valid = out_q.idle_valid;
    assign idle_pre_bank  = out_q.idle_bank;

    AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R9
    AST_NO_RSP_WITHOUT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid); // R9
    AST_HIT_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && bank_open[req_bank] && (bank_row[req_bank] == req_row)
        |=> rsp_class == 2'd0); // R1
    AST_IDLE_PRE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        idle_pre_valid |-> $past(!req_valid)); // R6
    AST_IDLE_PRE_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        idle_pre_valid |-> !bank_open[idle_pre_bank]); // R6
endmodule

// File: tb/test_apc_page_ctrl.sv
`timescale 1ns/1ps
module test_apc_page_ctrl;
    localparam int NB = 4;
    localparam int RW = 12;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 0, req_write = 0, req_next_new_row = 0;
    logic [1:0] req_bank = 0;
    logic [RW-1:0] req_row = 0;
    logic [4:0] cfg_hit_thresh = 5'd8;
    logic [7:0] cfg_idle_limit = 8'd200;
    logic rsp_valid, rsp_write, rsp_pre, rsp_act, rsp_col, rsp_auto_pre, idle_pre_valid;
    logic [1:0] rsp_bank, rsp_class, idle_pre_bank;
    logic [5:0] rsp_latency;
    logic [NB-1:0] bank_closed_mode;

    apc_page_ctrl i_apc_page_ctrl (.*);

    always #10 clk = ~clk;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // bench model
    int m_open[NB], m_row[NB], m_timer[NB], m_lv[NB], m_lr[NB], m_win[NB], m_hits[NB], m_mode[NB];
    int e_valid, e_bank, e_write, e_pre, e_act, e_auto, e_cls, e_lat, e_ivalid, e_ibank;

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int lat_of(int c);
        if (c == 0) return 3;
        if (c == 1) return 7;
        return 11;
    endfunction

    task automatic model_reset();
        for (int b = 0; b < NB; b++) begin
            m_open[b] = 0; m_row[b] = 0; m_timer[b] = 0; m_lv[b] = 0;
            m_lr[b] = 0; m_win[b] = 0; m_hits[b] = 0; m_mode[b] = 0;
        end
        e_valid = 0; e_ivalid = 0; e_ibank = 0;
    endtask

    task automatic model_step(int v, int b, int r, int wr, int nn);
        int ib;
        ib = -1;
        e_valid = v;
        if (v) begin
            int wh;
            e_bank = b; e_write = wr;
            e_cls = !m_open[b] ? 1 : (m_row[b] == r ? 0 : 2);
            e_pre = (e_cls == 2); e_act = (e_cls != 0);
            e_lat = lat_of(e_cls);
            e_auto = m_mode[b] | nn;
            wh = m_lv[b] && (m_lr[b] == r);
            m_lv[b] = 1; m_lr[b] = r;
            m_open[b] = !e_auto; m_row[b] = r; m_timer[b] = 0;
            if (m_win[b] == 15) begin
                m_mode[b] = (m_hits[b] + wh) < int'(cfg_hit_thresh);
                m_win[b] = 0; m_hits[b] = 0;
            end else begin
                m_win[b]++; m_hits[b] += wh;
            end
        end else begin
            for (int k = 0; k < NB; k++)
                if (ib < 0 && m_open[k] && m_timer[k] >= int'(cfg_idle_limit)) ib = k;
        end
        e_ivalid = (ib >= 0);
        if (ib >= 0) e_ibank = ib;
        for (int k = 0; k < NB; k++) begin
            if (v && k == b) continue;
            if (k == ib) begin m_open[k] = 0; m_timer[k] = 0; end
            else if (m_open[k] && m_timer[k] < 255) m_timer[k]++;
        end
    endtask

    task automatic check_outputs();
        chk("R9 rsp_valid", rsp_valid, e_valid);
        if (e_valid) begin
            chk("R1 class", rsp_class, e_cls);
            chk("R2 pre", rsp_pre, e_pre);
            chk("R2 act", rsp_act, e_act);
            chk("R2 col", rsp_col, 1);
            chk("R2 bank", rsp_bank, e_bank);
            chk("R2 write", rsp_write, e_write);
            chk("R3 latency", rsp_latency, e_lat);
            chk("R4 auto_pre", rsp_auto_pre, e_auto);
        end
        chk("R6 idle_valid", idle_pre_valid, e_ivalid);
        if (e_ivalid) chk("R6 idle_bank", idle_pre_bank, e_ibank);
        for (int b = 0; b < NB; b++) chk("R5 mode", bank_closed_mode[b], m_mode[b]);
    endtask

    // called at a falling edge: drive, predict, wait one cycle, check
    task automatic step(int v, int b, int r, int wr, int nn);
        req_valid = v[0]; req_bank = b[1:0]; req_row = r[RW-1:0];
        req_write = wr[0]; req_next_new_row = nn[0];
        model_step(v, b, r, wr, nn);
        @(negedge clk);
        check_outputs();
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        model_reset();
        repeat (3) @(negedge clk);
        // R8 reset state
        chk("R8 rsp_valid", rsp_valid, 0);
        chk("R8 idle_valid", idle_pre_valid, 0);
        chk("R8 modes", bank_closed_mode, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1/R2/R3 idle, hit, conflict on bank 0
        step(1, 0, 5, 0, 0);
        chk("R1 first access idle", rsp_class, 1);
        step(1, 0, 5, 1, 0);
        chk("R1 repeat is hit", rsp_class, 0);
        step(1, 0, 6, 0, 0);
        chk("R3 conflict latency", rsp_latency, 11);
        // R4 hint forces auto-precharge, next access finds bank idle
        step(1, 0, 6, 0, 1);
        chk("R4 hint auto_pre", rsp_auto_pre, 1);
        step(1, 0, 6, 0, 0);
        chk("R4 closed bank idle", rsp_class, 1);
        // R6 idle timeout on bank 1, R7 timer cleared by accesses on bank 2
        cfg_idle_limit = 8'd3;
        step(1, 1, 2, 0, 0);
        step(0, 0, 0, 0, 0);
        for (int i = 0; i < 4; i++) step(1, 2, 9, 0, 0);
        for (int i = 0; i < 6; i++) step(0, 0, 0, 0, 0);
        // R7: hits on bank 2 spaced below the limit keep the row open
        for (int i = 0; i < 5; i++) begin
            step(1, 2, 7, 0, 0);
            step(0, 0, 0, 0, 0);
            step(0, 0, 0, 0, 0);
            if (i > 0) chk("R7 row kept open", rsp_class, 0);
        end
        // R5 bank 3: no locality -> closed page, then strong locality -> open
        cfg_idle_limit = 8'd200;
        for (int i = 0; i < 16; i++) step(1, 3, (i % 2) + 1, 0, 0);
        chk("R5 low locality closes", bank_closed_mode[3], 1);
        chk("R5 other bank unaffected", bank_closed_mode[1], 0);
        for (int i = 0; i < 16; i++) begin
            step(1, 3, 4, 0, 0);
            if (i < 15) chk("R4 closed mode auto_pre", rsp_auto_pre, 1);
        end
        chk("R5 high locality reopens", bank_closed_mode[3], 0);
        // constrained random
        for (int i = 0; i < 4000; i++) begin
            int v, b, r, nn;
            if (i % 500 == 0) begin
                cfg_idle_limit = 8'($urandom_range(1, 24));
                cfg_hit_thresh = 5'($urandom_range(4, 12));
            end
            v  = ($urandom_range(0, 99) < 65);
            b  = $urandom_range(0, NB - 1);
            r  = ($urandom_range(0, 99) < 60) ? 3 : $urandom_range(0, 5);
            nn = ($urandom_range(0, 99) < 15);
            step(v, b, r, $urandom_range(0, 1), nn);
        end
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got %0d expected %0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule